// File: doc/BRIEF.md
# Hash accelerator control and DMA front-end

This block is the register-mapped control plane and input sequencer placed in front of a SHA-1/SHA-256 compression core. Software programs the algorithm and byte order, optionally loads eight 32-bit chaining words so a partial hash can be resumed, and issues a start. It then queues the message as word-aligned records of whole 64-byte blocks. Each record is described by an address and a byte length.

For each accepted record, a word-read master fetches the message one word at a time over a valid/ready request channel. The words are packed sixteen to a 512-bit block, and each block is handed to the core. The core answers every block with an updated 256-bit digest. The block tracks readiness flags, a sticky error state and a 64-bit running byte count. The most recent digest is exposed as eight readable words.

Top module: `hash_dma_front`

## Requirements
- R1: Status (offset 0x08) holds bit0 engine ready, bit1 fetch idle, bit2 block waiting at the core, bit3 record ready, bits 5:4 error code, bit6 length error; all other bits read 0. Writes to it have no effect. Engine ready is 0 after reset and rises WAKE_CYC cycles after reset release, and is 0 while a record is in progress.
- R2: Control (offset 0x0C) stores bits 6:0 (2:1 algorithm, 0 = SHA-1 and 1 = SHA-256; 5 byte swap; 6 load chaining state) and reads 0 above them. Reads of offsets that no register decodes return 0.
- R3: Writing 1 to bit0 of offset 0x10 while engine ready is 0 is ignored: no state load reaches the core, and the error code becomes 2'b10.
- R4: An accepted start latches the algorithm and byte-swap selection, pulses core_init_load for one cycle one cycle later, and drives core_init_use from control bit6. core_init_state carries the eight words at 0x90..0xAC, with the word at 0x90 in bits 255:224. A start also clears the error code and the length error.
- R5: Writing the length (offset 0x18) while record ready is 1 starts a record at the address last written to 0x14 and drops record ready. It is refused with the length error set when the address is not a multiple of 4, the length is zero, or the length is not a multiple of 64. Offset 0x20 reads the last accepted length and 0x24 reads 0.
- R6: A length write while record ready is 0 is ignored (the last accepted length and the request stream are unchanged) and sets the error code to 2'b01.
- R7: Requests go out one at a time, at ascending word addresses from the record base. A new request is never raised in the cycle after a request is accepted. The first word of each group of sixteen occupies bits 511:480 of the block.
- R8: With byte swap latched, each fetched word is byte-reversed before packing.
- R9: Record ready returns to 1 only after every block of the record has been answered by the core. Digest words at 0x30..0x4C then hold the last core digest, with the word at 0x30 taken from bits 255:224.
- R10: The 64-bit count at 0x00 (low) and 0x04 (high) is zeroed by an accepted start, grows by 64 per block handed to the core, and carries across records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Word read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| core_init_load | output | 1 | One-cycle pulse: reset chaining value |
| core_init_use | output | 1 | 1: load core_init_state, 0: standard initial value |
| core_init_state | output | 256 | Injected chaining value |
| core_alg | output | 2 | Latched algorithm code |
| core_blk_valid | output | 1 | 512-bit block valid |
| core_blk_ready | input | 1 | Core accepts block |
| core_blk_data | output | 512 | Message block |
| core_dig_valid | input | 1 | Core digest valid, one per accepted block |
| core_dig_data | input | 256 | Core digest |

## Verification
The assertions assume that the memory returns exactly one response for each accepted request, no sooner than the cycle after acceptance. They also assume that the core answers each accepted block with a single digest pulse and never produces one unprompted. The bench stubs keep to this. The memory stub replies exactly one cycle after each handshake and throttles acceptance with a pseudo-random pattern. The core stub holds its ready low from acceptance until it has returned the digest.

// File: rtl/hdf_pkg.sv
package hdf_pkg;
   localparam logic [7:0] OFS_TOT_LO  = 8'h00;
   localparam logic [7:0] OFS_TOT_HI  = 8'h04;
   localparam logic [7:0] OFS_STAT    = 8'h08;
   localparam logic [7:0] OFS_CTRL    = 8'h0C;
   localparam logic [7:0] OFS_GO      = 8'h10;
   localparam logic [7:0] OFS_ADDR    = 8'h14;
   localparam logic [7:0] OFS_LEN     = 8'h18;
   localparam logic [7:0] OFS_RLEN_LO = 8'h20;
   localparam logic [7:0] OFS_RLEN_HI = 8'h24;
   localparam logic [7:0] OFS_DIG0    = 8'h30;
   localparam logic [7:0] OFS_IV0     = 8'h90;

   typedef enum logic [1:0] {
      ERR_NONE   = 2'b00,
      ERR_BUSY   = 2'b01,
      ERR_NOTRDY = 2'b10
   } err_e;
endpackage

// File: rtl/hdf_fetch.sv
module hdf_fetch #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DW     = 32,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  nwords,
   input  logic              slot_free,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   input  logic              rsp_valid,
   input  logic [DW-1:0]     rsp_data,
   output logic              push,
   output logic [DW-1:0]     push_data,
   output logic              idle
);
   localparam int unsigned STEP = DW / 8;

   if (DW % 8 != 0) begin : g_bad_dw
      $error("hdf_fetch: DW must be a whole number of bytes");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic              wait_q;
   logic              fire;

   assign req_valid = (left_q != '0) && !wait_q && slot_free;
   assign req_addr  = addr_q;
   assign fire      = req_valid && req_ready;
   assign push      = rsp_valid && wait_q;
   assign push_data = rsp_data;
   assign idle      = (left_q == '0) && !wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
         wait_q <= 1'b0;
      end else begin
         if (load) begin
            addr_q <= base;
            left_q <= nwords;
         end else if (fire) begin
            addr_q <= addr_q + ADDR_W'(STEP);
            left_q <= left_q - CNT_W'(1);
         end
         if (fire)           wait_q <= 1'b1;
         else if (rsp_valid) wait_q <= 1'b0;
      end
   end

   AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !req_valid); // R7
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (addr_q == $past(addr_q) + ADDR_W'(STEP))); // R7
endmodule

// File: rtl/hdf_pack.sv
module hdf_pack #(
   parameter int unsigned DW      = 32,
   parameter int unsigned BLK_W   = 512,
   parameter bit          SWAP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [DW-1:0]    push_data,
   input  logic             swap,
   output logic             blk_valid,
   input  logic             blk_ready,
   output logic [BLK_W-1:0] blk_data,
   output logic             slot_free,
   output logic             empty
);
   localparam int unsigned NW = BLK_W / DW;
   localparam int unsigned CW = $clog2(NW + 1);
   localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1;
   localparam int unsigned NB = DW / 8;

   if (BLK_W % DW != 0) begin : g_bad_blk
      $error("hdf_pack: BLK_W must be a multiple of DW");
   end
   if (DW % 8 != 0) begin : g_bad_dw
      $error("hdf_pack: DW must be a whole number of bytes");
   end

   logic [DW-1:0] word_in;
   logic [DW-1:0] slot_q [NW];
   logic [CW-1:0] cnt_q;
   logic          full;

   if (SWAP_EN) begin : g_swap
      logic [DW-1:0] rev;
      always_comb begin
         for (int b = 0; b < NB; b++)
            rev[8*b +: 8] = push_data[DW-8-8*b +: 8];
      end
      assign word_in = swap ? rev : push_data;
   end else begin : g_pass
      logic unused_swap;
      assign unused_swap = swap;
      assign word_in     = push_data;
   end

   assign full      = (cnt_q == CW'(NW));
   assign blk_valid = full;
   assign slot_free = !full;
   assign empty     = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (blk_valid && blk_ready) cnt_q <= '0;
      else if (push && !full)          cnt_q <= cnt_q + CW'(1);
   end

   always_ff @(posedge clk) begin
      if (push && !full) slot_q[IW'(cnt_q)] <= word_in;
   end

   for (genvar i = 0; i < NW; i++) begin : g_lane
      assign blk_data[BLK_W-1-i*DW -: DW] = slot_q[i];
   end

   AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_data))); // R7
   AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push); // R7
endmodule

// File: rtl/hdf_regs.sv
module hdf_regs
   import hdf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ST_W      = 256,
   parameter int unsigned BLK_BYTES = 64,
   parameter int unsigned WAKE_CYC  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              fetch_load,
   output logic [ADDR_W-1:0] fetch_base,
   output logic [CNT_W-1:0]  fetch_nwords,
   input  logic              fetch_idle,
   input  logic              pack_empty,
   input  logic              blk_pending,
   input  logic              blk_fire,
   input  logic              dig_valid,
   input  logic [ST_W-1:0]   dig_data,
   output logic              swap,
   output logic              core_init_load,
   output logic              core_init_use,
   output logic [ST_W-1:0]   core_init_state,
   output logic [1:0]        core_alg,
   output logic              rec_rdy
);
   localparam int unsigned NS   = ST_W / 32;
   localparam int unsigned SW   = (NS > 1) ? $clog2(NS) : 1;
   localparam int unsigned WK_W = $clog2(WAKE_CYC + 1);
   localparam int unsigned LOG_B = $clog2(BLK_BYTES);

   if (ST_W % 32 != 0 || NS > 8) begin : g_bad_st
      $error("hdf_regs: ST_W must be 32 to 256 in 32-bit steps");
   end
   if (ADDR_W > 32 || CNT_W + 2 > 32) begin : g_bad_w
      $error("hdf_regs: address or count wider than the register port");
   end
   if (WAKE_CYC < 1 || (1 << LOG_B) != BLK_BYTES) begin : g_bad_misc
      $error("hdf_regs: WAKE_CYC >= 1 and power-of-two BLK_BYTES required");
   end

   logic [WK_W-1:0]   wake_q;
   logic              woke;
   logic [6:0]        ctrl_q;
   logic [1:0]        alg_q;
   logic              swap_q;
   logic              init_q, init_use_q;
   logic [31:0]       iv_q  [NS];
   logic [31:0]       dig_q [NS];
   logic [63:0]       tot_q;
   logic [31:0]       rlen_q;
   logic [ADDR_W-1:0] base_q;
   err_e              err_q;
   logic              lerr_q;
   logic              act_q;
   logic              cbusy_q;

   logic       hash_rdy, wr_go, start_ok, wr_len, len_bad, rec_ok, rec_done;
   logic [7:0] dig_off, iv_off;
   logic       dig_hit, iv_hit;

   assign woke     = (wake_q == WK_W'(WAKE_CYC));
   assign hash_rdy = woke && !act_q;
   assign wr_go    = reg_wr && (reg_addr == OFS_GO) && reg_wdata[0];
   assign start_ok = wr_go && hash_rdy;
   assign wr_len   = reg_wr && (reg_addr == OFS_LEN);
   assign len_bad  = (base_q[1:0] != 2'b00) || (reg_wdata == '0) ||
                     (reg_wdata[LOG_B-1:0] != '0) ||
                     ((reg_wdata >> (CNT_W + 2)) != '0);
   assign rec_ok   = wr_len && !act_q && !len_bad;
   assign rec_done = act_q && fetch_idle && pack_empty && !cbusy_q;

   assign dig_off = reg_addr - OFS_DIG0;
   assign iv_off  = reg_addr - OFS_IV0;
   assign dig_hit = (reg_addr >= OFS_DIG0) && (dig_off < 8'(4 * NS)) && (reg_addr[1:0] == 2'b00);
   assign iv_hit  = (reg_addr >= OFS_IV0)  && (iv_off  < 8'(4 * NS)) && (reg_addr[1:0] == 2'b00);

   assign fetch_load   = rec_ok;
   assign fetch_base   = base_q;
   assign fetch_nwords = reg_wdata[CNT_W+1:2];
   assign swap           = swap_q;
   assign core_alg       = alg_q;
   assign core_init_load = init_q;
   assign core_init_use  = init_use_q;
   assign rec_rdy        = !act_q;

   for (genvar i = 0; i < NS; i++) begin : g_iv
      assign core_init_state[ST_W-1-32*i -: 32] = iv_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q     <= '0;
         ctrl_q     <= '0;
         alg_q      <= '0;
         swap_q     <= 1'b0;
         init_q     <= 1'b0;
         init_use_q <= 1'b0;
         tot_q      <= '0;
         rlen_q     <= '0;
         base_q     <= '0;
         err_q      <= ERR_NONE;
         lerr_q     <= 1'b0;
         act_q      <= 1'b0;
         cbusy_q    <= 1'b0;
         for (int i = 0; i < NS; i++) begin
            iv_q[i]  <= '0;
            dig_q[i] <= '0;
         end
      end else begin
         if (!woke) wake_q <= wake_q + WK_W'(1);

         if (reg_wr && reg_addr == OFS_CTRL) ctrl_q <= reg_wdata[6:0];
         if (reg_wr && reg_addr == OFS_ADDR) base_q <= reg_wdata[ADDR_W-1:0];
         if (reg_wr && iv_hit) iv_q[iv_off[SW+1:2]] <= reg_wdata;

         init_q <= start_ok;
         if (start_ok) begin
            alg_q      <= ctrl_q[2:1];
            swap_q     <= ctrl_q[5];
            init_use_q <= ctrl_q[6];
         end

         if (start_ok) begin
            err_q  <= ERR_NONE;
            lerr_q <= 1'b0;
         end else begin
            if (wr_go)                      err_q  <= ERR_NOTRDY;
            if (wr_len && act_q)            err_q  <= ERR_BUSY;
            if (wr_len && !act_q && len_bad) lerr_q <= 1'b1;
         end

         if (rec_ok) begin
            act_q  <= 1'b1;
            rlen_q <= reg_wdata;
         end else if (rec_done) begin
            act_q  <= 1'b0;
         end

         if (blk_fire)       cbusy_q <= 1'b1;
         else if (dig_valid) cbusy_q <= 1'b0;

         if (start_ok)      tot_q <= '0;
         else if (blk_fire) tot_q <= tot_q + 64'(BLK_BYTES);

         if (dig_valid) begin
            for (int i = 0; i < NS; i++) dig_q[i] <= dig_data[ST_W-1-32*i -: 32];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFS_TOT_LO)       reg_rdata = tot_q[31:0];
      else if (reg_addr == OFS_TOT_HI)  reg_rdata = tot_q[63:32];
      else if (reg_addr == OFS_STAT)    reg_rdata = {25'd0, lerr_q, err_q, rec_rdy,
                                                     blk_pending, fetch_idle, hash_rdy};
      else if (reg_addr == OFS_CTRL)    reg_rdata = {25'd0, ctrl_q};
      else if (reg_addr == OFS_ADDR)    reg_rdata = 32'(base_q);
      else if (reg_addr == OFS_RLEN_LO) reg_rdata = rlen_q;
      else if (dig_hit)                 reg_rdata = dig_q[dig_off[SW+1:2]];
      else if (iv_hit)                  reg_rdata = iv_q[iv_off[SW+1:2]];
   end

   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      core_init_load |-> $past(hash_rdy)); // R3
   AST_REC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rec_rdy) |-> $past(wr_len)); // R5
   AST_IDLE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_q && !start_ok) |=> $stable(tot_q)); // R10
   AST_DIG_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
      dig_valid |-> cbusy_q); // R9
endmodule

// File: rtl/hash_dma_front.sv
module hash_dma_front #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned WAKE_CYC = 8,
   parameter bit          SWAP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   output logic              core_init_load,
   output logic              core_init_use,
   output logic [255:0]      core_init_state,
   output logic [1:0]        core_alg,
   output logic              core_blk_valid,
   input  logic              core_blk_ready,
   output logic [511:0]      core_blk_data,
   input  logic              core_dig_valid,
   input  logic [255:0]      core_dig_data
);
   localparam int unsigned DW        = 32;
   localparam int unsigned BLK_W     = 512;
   localparam int unsigned ST_W      = 256;
   localparam int unsigned BLK_BYTES = BLK_W / 8;

   logic              f_load, f_idle, f_push, p_free, p_empty, swap, rec_rdy, blk_fire;
   logic [ADDR_W-1:0] f_base;
   logic [CNT_W-1:0]  f_nwords;
   logic [DW-1:0]     f_word;

   assign blk_fire = core_blk_valid && core_blk_ready;

   hdf_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ST_W(ST_W),
              .BLK_BYTES(BLK_BYTES), .WAKE_CYC(WAKE_CYC)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fetch_load(f_load), .fetch_base(f_base), .fetch_nwords(f_nwords),
      .fetch_idle(f_idle), .pack_empty(p_empty), .blk_pending(core_blk_valid),
      .blk_fire(blk_fire), .dig_valid(core_dig_valid), .dig_data(core_dig_data),
      .swap(swap), .core_init_load(core_init_load), .core_init_use(core_init_use),
      .core_init_state(core_init_state), .core_alg(core_alg), .rec_rdy(rec_rdy));

   hdf_fetch #(.ADDR_W(ADDR_W), .DW(DW), .CNT_W(CNT_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .load(f_load), .base(f_base), .nwords(f_nwords),
      .slot_free(p_free), .req_valid(mem_req_valid), .req_ready(mem_req_ready),
      .req_addr(mem_req_addr), .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
      .push(f_push), .push_data(f_word), .idle(f_idle));

   hdf_pack #(.DW(DW), .BLK_W(BLK_W), .SWAP_EN(SWAP_EN)) u_pack (
      .clk(clk), .rst_n(rst_n), .push(f_push), .push_data(f_word), .swap(swap),
      .blk_valid(core_blk_valid), .blk_ready(core_blk_ready),
      .blk_data(core_blk_data), .slot_free(p_free), .empty(p_empty));

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rec_rdy |-> !mem_req_valid); // R9
   AST_IDLE_NO_BLK: assert property (@(posedge clk) disable iff (!rst_n)
      rec_rdy |-> !core_blk_valid); // R9
endmodule

// File: tb/sim_hash_dma_front.sv
module sim_hash_dma_front;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [7:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         mem_req_valid;
   logic         mem_req_ready = 1'b0;
   logic [31:0]  mem_req_addr;
   logic         mem_rsp_valid = 1'b0;
   logic [31:0]  mem_rsp_data = '0;
   logic         core_init_load, core_init_use;
   logic [255:0] core_init_state;
   logic [1:0]   core_alg;
   logic         core_blk_valid;
   logic         core_blk_ready = 1'b0;
   logic [511:0] core_blk_data;
   logic         core_dig_valid = 1'b0;
   logic [255:0] core_dig_data = '0;

   hash_dma_front u0 (.*);

   int n_chk = 0, n_bad = 0;
   logic [31:0]  exp_addr_q [$];
   logic [511:0] exp_blk_q  [$];
   logic [255:0] ref_chain;
   logic [255:0] stub_chain = '0;
   int           init_cnt = 0;
   logic         seen_use = 1'b0;
   logic [255:0] seen_state = '0;
   logic [1:0]   seen_alg = '0;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(logic [31:0] a);
      return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0000;
   endfunction
   function automatic logic [31:0] swap32(logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction
   function automatic logic [255:0] mix(logic [255:0] c, logic [511:0] b);
      return {c[247:0], c[255:248]} ^ b[511:256] ^ b[255:0];
   endfunction
   function automatic logic [255:0] std_iv(logic [1:0] alg);
      return (alg == 2'd1) ? {8{32'h6A09E667}} : {8{32'h67452301}};
   endfunction

   // memory stub: accepts with a pseudo-random pattern, answers one cycle later
   logic [7:0]  lfsr = 8'hA5;
   logic        hs_pend = 1'b0;
   logic [31:0] hs_addr = '0;
   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (hs_pend) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = mem_word(hs_addr);
         hs_pend = 1'b0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = 1'b0;
      if (rst_n && mem_req_valid && lfsr[0]) begin
         if (exp_addr_q.size() == 0) begin
            check("R7 unexpected request", 64'(mem_req_addr), 64'hFFFF_FFFF);
         end else begin
            check("R7 request address", 64'(mem_req_addr), 64'(exp_addr_q.pop_front()));
         end
         mem_req_ready = 1'b1;
         hs_pend = 1'b1;
         hs_addr = mem_req_addr;
      end
   end

   // core stub: one block at a time, digest three cycles after acceptance
   logic blk_hs = 1'b0;
   int   busy = 0;
   always @(negedge clk) begin
      core_dig_valid = 1'b0;
      if (rst_n && core_init_load) begin
         init_cnt++;
         seen_use   = core_init_use;
         seen_state = core_init_state;
         seen_alg   = core_alg;
         stub_chain = core_init_use ? core_init_state : std_iv(core_alg);
      end
      if (blk_hs) begin
         blk_hs = 1'b0;
         busy = 3;
      end
      core_blk_ready = 1'b0;
      if (busy > 0) begin
         busy--;
         if (busy == 0) begin
            core_dig_valid = 1'b1;
            core_dig_data  = stub_chain;
         end
      end else if (rst_n && core_blk_valid) begin
         if (exp_blk_q.size() == 0) begin
            check("R7 unexpected block", 64'(core_blk_data[511:480]), 64'hFFFF_FFFF);
         end else begin
            logic [511:0] e;
            e = exp_blk_q.pop_front();
            n_chk++;
            if (core_blk_data !== e) begin
               n_bad++;
               $display("FAIL R7/R8 block actual=%h expected=%h", core_blk_data, e);
            end
         end
         stub_chain = mix(stub_chain, core_blk_data);
         core_blk_ready = 1'b1;
         blk_hs = 1'b1;
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic chk_rd(string tag, logic [7:0] a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(tag, 64'(d), 64'(exp));
   endtask

   task automatic queue_record(logic [31:0] base, int nbytes, bit sw);
      logic [511:0] blk;
      blk = '0;
      for (int i = 0; i < nbytes / 4; i++) begin
         logic [31:0] w;
         w = mem_word(base + 32'(4 * i));
         if (sw) w = swap32(w);
         exp_addr_q.push_back(base + 32'(4 * i));
         blk[511 - 32 * (i % 16) -: 32] = w;
         if (i % 16 == 15) begin
            exp_blk_q.push_back(blk);
            ref_chain = mix(ref_chain, blk);
         end
      end
   endtask

   task automatic wait_rec(string tag);
      logic [31:0] d;
      d = '0;
      for (int k = 0; k < 3000 && !d[3]; k++) rd(8'h08, d);
      check(tag, 64'(d[3]), 64'd1);
   endtask

   task automatic chk_digest(string tag);
      for (int i = 0; i < 8; i++)
         chk_rd(tag, 8'(8'h30 + 4 * i), ref_chain[255 - 32 * i -: 32]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [255:0] ivs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, engine not yet ready
      chk_rd("R1 status after reset", 8'h08, 32'h0000_000A);
      // R3: start before engine ready is refused
      wr(8'h10, 32'h1);
      chk_rd("R3 refused start error code", 8'h08, 32'h0000_002A);
      check("R3 no state load", 64'(init_cnt), 64'd0);
      repeat (12) @(negedge clk);
      chk_rd("R1 engine ready rises", 8'h08, 32'h0000_002B);
      wr(8'h08, 32'hFFFF_FFFF);
      chk_rd("R1 status read-only", 8'h08, 32'h0000_002B);
      // R2: control field mask and unmapped reads
      wr(8'h0C, 32'hFFFF_FF82);
      chk_rd("R2 control readback", 8'h0C, 32'h0000_0002);
      chk_rd("R2 unmapped 0x5C", 8'h5C, 32'h0);
      chk_rd("R2 unmapped 0x28", 8'h28, 32'h0);
      // R4: injected chaining state
      for (int i = 0; i < 8; i++) begin
         wr(8'(8'h90 + 4 * i), 32'h1000_0000 + 32'(i * 32'h0101));
         ivs[255 - 32 * i -: 32] = 32'h1000_0000 + 32'(i * 32'h0101);
      end
      wr(8'h0C, 32'h42);
      wr(8'h10, 32'h1);
      @(negedge clk);
      check("R4 one state load", 64'(init_cnt), 64'd1);
      check("R4 load uses state", 64'(seen_use), 64'd1);
      check("R4 state word order hi", seen_state[255:192], ivs[255:192]);
      check("R4 state word order lo", seen_state[63:0], ivs[63:0]);
      check("R4 algorithm latched", 64'(seen_alg), 64'd1);
      chk_rd("R4 start clears error", 8'h08, 32'h0000_000B);
      // R5: misaligned address refused
      wr(8'h14, 32'h0000_0102);
      wr(8'h18, 32'd64);
      chk_rd("R5 misaligned sets length error", 8'h08, 32'h0000_004B);
      repeat (10) @(negedge clk);
      chk_rd("R5 refused record moves nothing", 8'h00, 32'h0);
      wr(8'h10, 32'h1);
      wr(8'h14, 32'h0000_0100);
      wr(8'h18, 32'd100);
      chk_rd("R5 odd length sets length error", 8'h08, 32'h0000_004B);
      wr(8'h18, 32'd0);
      chk_rd("R5 zero length refused", 8'h20, 32'h0);
      // R9/R6/R7: two-block record from injected state
      wr(8'h10, 32'h1);
      ref_chain = ivs;
      wr(8'h14, 32'h0000_0200);
      queue_record(32'h200, 128, 1'b0);
      wr(8'h18, 32'd128);
      begin
         logic [31:0] d;
         rd(8'h08, d);
         check("R9 record ready drops", 64'(d[3]), 64'd0);
         check("R1 engine not ready while busy", 64'(d[0]), 64'd0);
      end
      wr(8'h18, 32'd64);
      wait_rec("R9 record ready returns");
      chk_rd("R6 busy write error code", 8'h08, 32'h0000_001B);
      chk_rd("R6 last accepted length kept", 8'h20, 32'd128);
      chk_rd("R5 length high reads 0", 8'h24, 32'h0);
      check("R7 all addresses requested", 64'(exp_addr_q.size()), 64'd0);
      chk_digest("R9 digest word");
      chk_rd("R10 total low", 8'h00, 32'd128);
      chk_rd("R10 total high", 8'h04, 32'd0);
      // R8: byte-swapped record with standard initial value
      wr(8'h0C, 32'h22);
      wr(8'h10, 32'h1);
      @(negedge clk);
      check("R4 standard value selected", 64'(seen_use), 64'd0);
      chk_rd("R10 start zeroes total", 8'h00, 32'd0);
      ref_chain = std_iv(2'd1);
      wr(8'h14, 32'h0000_0400);
      queue_record(32'h400, 64, 1'b1);
      wr(8'h18, 32'd64);
      wait_rec("R8 swapped record done");
      chk_digest("R8 swapped digest");
      // R10: next record accumulates without a start
      wr(8'h14, 32'h0000_0800);
      queue_record(32'h800, 192, 1'b1);
      wr(8'h18, 32'd192);
      wait_rec("R10 third record done");
      chk_digest("R10 chained digest");
      chk_rd("R10 total carries", 8'h00, 32'd256);
      // R4: SHA-1 code latched
      wr(8'h0C, 32'h0);
      wr(8'h10, 32'h1);
      @(negedge clk);
      check("R4 algorithm SHA-1", 64'(seen_alg), 64'd0);
      check("R7 no stray blocks", 64'(exp_blk_q.size()), 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule